// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Deferral Credit

This block decides when a memory controller should send AUTO REFRESH commands to a DDR SDRAM. An interval timer runs freely. Each time it expires, the block adds one refresh to a count of owed refreshes. While the controller reports heavy traffic, the block holds its refresh request back. The debt then grows, up to a fixed limit. When traffic is quiet, the block requests refreshes whenever any are owed, so the debt is paid down early.

When the debt reaches its limit, the block raises the request together with an urgent flag. The controller must grant that request before the next interval expires. Then the time between two refresh commands never exceeds the limit plus one nominal intervals.

A grant that arrives while the request is high is accepted on that clock edge. In the following cycle the block emits a one-cycle command strobe and lowers the debt by one. It then reports the device busy for the refresh cycle time. During that busy window it makes no request, so no other command goes to the device while the refresh is in progress.

Top module: `refresh_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, ref_req_o, ref_urgent_o, ref_cmd_o and dev_busy_o are all 0. The owed count is 0.
- R2: Each time INTERVAL_CYC clock edges have passed since reset was released, the owed count rises by one. With ref_grant_i low and traffic_busy_i low, ref_req_o goes to 1 in the cycle right after the first expiry and not before.
- R3: ref_req_o is 1 only when at least one refresh is owed and the device is not busy. When traffic_busy_i is 0, a pending debt produces a request.
- R4: While traffic_busy_i is 1, ref_req_o stays 0 as long as the owed count is below MAX_OWED.
- R5: ref_urgent_o is 1 exactly when the owed count equals MAX_OWED. While traffic_busy_i is 1, the request rises in the same cycle as urgent.
- R6: The owed count never exceeds MAX_OWED and never drops below 0.
- R7: A cycle with ref_req_o and ref_grant_i both 1 is followed by exactly one cycle with ref_cmd_o at 1. In that cycle the owed count has dropped by one, not counting a timer expiry at the same edge.
- R8: ref_grant_i while ref_req_o is 0 has no effect: ref_cmd_o stays 0 in the next cycle.
- R9: dev_busy_o is 1 for exactly TRFC_CYC cycles, starting with the ref_cmd_o cycle, and ref_req_o stays 0 throughout. Under constant grant and quiet traffic, consecutive commands are TRFC_CYC+1 cycles apart.
- R10: If every urgent request is granted in the cycle it appears, the gap between consecutive ref_cmd_o pulses is at most (MAX_OWED+1)*INTERVAL_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_grant_i | input | 1 | Command path accepts the pending refresh request |
| traffic_busy_i | input | 1 | Controller hint that traffic is heavy, so refresh should be deferred |
| ref_req_o | output | 1 | Refresh request |
| ref_urgent_o | output | 1 | Deferral limit reached; the refresh must be granted now |
| ref_cmd_o | output | 1 | One-cycle AUTO REFRESH command strobe |
| dev_busy_o | output | 1 | Device is inside its refresh cycle time |

## Verification
The hardest state to reach from the ports is a full debt: the owed count at its limit, with the urgent flag up and the interval timer still running. The bench holds the traffic hint high and withholds grants for eight whole intervals. It follows the debt with its own model, built from edges since reset and observed command strobes. It then grants exactly in the urgent cycle. From that full debt it releases the hint with a constant grant, so the back-to-back catch-up spacing is measured. A last phase grants only on urgent, to bound the worst-case gap between commands.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  // Request-path state of the scheduler
  typedef enum logic [1:0] {
    RS_QUIET = 2'd0,
    RS_ASK   = 2'd1,
    RS_RFC   = 2'd2
  } rs_state_e;

  function automatic int unsigned bits_for(input int unsigned value);
    int unsigned w;
    w = 1;
    while ((1 << w) <= value) w++;
    return w;
  endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int unsigned INTERVAL_CYC = 1953
) (
  input  logic clk,
  input  logic rst,
  output logic expire_o
);
  localparam int unsigned TW   = refresh_sched_pkg::bits_for(INTERVAL_CYC - 1);
  localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

  logic [TW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (count_q == LAST) begin
      count_q <= '0;
    end else begin
      count_q <= count_q + 1'b1;
    end
  end

  assign expire_o = (count_q == LAST);

endmodule

// File: rtl/refresh_debt_counter.sv
module refresh_debt_counter #(
  parameter int unsigned MAX_OWED = 8,
  parameter int unsigned OWED_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              add_i,
  input  logic              pay_i,
  output logic [OWED_W-1:0] owed_o,
  output logic [OWED_W-1:0] owed_next_o
);
  localparam logic [OWED_W-1:0] LIMIT = OWED_W'(MAX_OWED);

  logic [OWED_W-1:0] owed_q;
  logic [OWED_W-1:0] owed_d;

  always_comb begin
    owed_d = owed_q;
    if (add_i && !pay_i) begin
      if (owed_q != LIMIT) owed_d = owed_q + 1'b1;
    end else if (pay_i && !add_i) begin
      if (owed_q != '0) owed_d = owed_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) owed_q <= '0;
    else     owed_q <= owed_d;
  end

  assign owed_o      = owed_q;
  assign owed_next_o = owed_d;

endmodule

// File: rtl/refresh_rfc_window.sv
module refresh_rfc_window #(
  parameter int unsigned TRFC_CYC = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic busy_next_o
);
  localparam int unsigned CW = refresh_sched_pkg::bits_for(TRFC_CYC);
  localparam logic [CW-1:0] LOAD = CW'(TRFC_CYC - 1);

  logic [CW-1:0] left_q;
  logic          busy_q;
  logic          busy_d;

  assign busy_d = start_i | (busy_q & (left_q != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      if (start_i)             left_q <= LOAD;
      else if (left_q != '0)   left_q <= left_q - 1'b1;
    end
  end

  assign busy_o      = busy_q;
  assign busy_next_o = busy_d;

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int unsigned INTERVAL_CYC = 1953,
  parameter int unsigned MAX_OWED     = 8,
  parameter int unsigned TRFC_CYC     = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_grant_i,
  input  logic traffic_busy_i,
  output logic ref_req_o,
  output logic ref_urgent_o,
  output logic ref_cmd_o,
  output logic dev_busy_o
);
  import refresh_sched_pkg::*;

  localparam int unsigned OWED_W = bits_for(MAX_OWED);
  localparam logic [OWED_W-1:0] LIMIT = OWED_W'(MAX_OWED);

  logic              expire;
  logic              issue;
  logic [OWED_W-1:0] debt_q;
  logic [OWED_W-1:0] debt_d;
  logic              busy_q;
  logic              busy_d;
  logic              urgent_d;
  rs_state_e         state_q;
  rs_state_e         state_d;
  logic              cmd_q;
  logic              urgent_q;

  refresh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .expire_o (expire)
  );

  refresh_debt_counter #(.MAX_OWED(MAX_OWED), .OWED_W(OWED_W)) u_debt (
    .clk         (clk),
    .rst         (rst),
    .add_i       (expire),
    .pay_i       (issue),
    .owed_o      (debt_q),
    .owed_next_o (debt_d)
  );

  refresh_rfc_window #(.TRFC_CYC(TRFC_CYC)) u_rfc (
    .clk         (clk),
    .rst         (rst),
    .start_i     (issue),
    .busy_o      (busy_q),
    .busy_next_o (busy_d)
  );

  // A grant only counts while the request is presented
  assign issue    = (state_q == RS_ASK) & ref_grant_i;
  assign urgent_d = (debt_d == LIMIT);

  always_comb begin
    if (busy_d) begin
      state_d = RS_RFC;
    end else if ((debt_d != '0) && (!traffic_busy_i || urgent_d)) begin
      state_d = RS_ASK;
    end else begin
      state_d = RS_QUIET;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= RS_QUIET;
      cmd_q    <= 1'b0;
      urgent_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cmd_q    <= issue;
      urgent_q <= urgent_d;
    end
  end

  assign ref_req_o    = (state_q == RS_ASK);
  assign ref_urgent_o = urgent_q;
  assign ref_cmd_o    = cmd_q;
  assign dev_busy_o   = busy_q;

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int unsigned MAX_OWED = 8,
  parameter int unsigned OWED_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              grant,
  input logic              urgent,
  input logic              cmd,
  input logic              busy,
  input logic [OWED_W-1:0] owed
);

  // R6
  debt_range_chk: assert property (@(posedge clk) disable iff (rst)
    owed <= OWED_W'(MAX_OWED));

  // R5
  urgent_level_chk: assert property (@(posedge clk) disable iff (rst)
    urgent == (owed == OWED_W'(MAX_OWED)));

  // R3
  req_needs_debt_chk: assert property (@(posedge clk) disable iff (rst)
    req |-> (owed != '0));

  // R7
  cmd_origin_chk: assert property (@(posedge clk) disable iff (rst)
    cmd |-> $past(req && grant));

  // R7
  cmd_single_chk: assert property (@(posedge clk) disable iff (rst)
    cmd |=> !cmd);

  // R8
  grant_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (grant && !req) |=> !cmd);

  // R9
  busy_blocks_req_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req);

  // R9
  cmd_opens_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd |-> (busy && !$past(busy)));

endmodule

bind refresh_sched refresh_sched_chk #(
  .MAX_OWED (MAX_OWED),
  .OWED_W   (OWED_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .req    (ref_req_o),
  .grant  (ref_grant_i),
  .urgent (ref_urgent_o),
  .cmd    (ref_cmd_o),
  .busy   (dev_busy_o),
  .owed   (debt_q)
);

// File: tb/test_refresh_sched.sv
module test_refresh_sched;
  localparam int IVL  = 40;
  localparam int MAXD = 8;
  localparam int TRFC = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic grant = 1'b0;
  logic hint = 1'b0;
  logic req, urgent, cmd, busy;

  int n_chk  = 0;
  int n_fail = 0;
  int edges  = 0;
  int ncmd   = 0;
  int model  = 0;
  int busy_left = 0;
  int since_cmd = 0;
  int max_gap = 0;
  int mis_r3 = 0, mis_r5 = 0, mis_r6 = 0, mis_r9 = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  refresh_sched #(.INTERVAL_CYC(IVL), .MAX_OWED(MAXD), .TRFC_CYC(TRFC)) i_refresh_sched (
    .clk            (clk),
    .rst            (rst),
    .ref_grant_i    (grant),
    .traffic_busy_i (hint),
    .ref_req_o      (req),
    .ref_urgent_o   (urgent),
    .ref_cmd_o      (cmd),
    .dev_busy_o     (busy)
  );

  always @(posedge clk) if (!rst) edges <= edges + 1;

  // Independent debt model: expiries seen minus commands seen
  always @(negedge clk) begin
    if (!rst) begin
      if (cmd) begin
        ncmd++;
        if (ncmd > 1 && since_cmd > max_gap) max_gap = since_cmd;
        since_cmd = 0;
        busy_left = TRFC;
      end
      since_cmd++;
      model = edges / IVL - ncmd;
      if (model < 0 || model > MAXD) mis_r6++;
      if (urgent != (model == MAXD)) mis_r5++;
      if (req && model == 0) mis_r3++;
      if (busy != (busy_left > 0)) mis_r9++;
      if (busy && req) mis_r9++;
      if (busy_left > 0) busy_left--;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req == 0, "R1 req in reset", req, 0);
    chk(urgent == 0, "R1 urgent in reset", urgent, 0);
    chk(cmd == 0, "R1 cmd in reset", cmd, 0);
    chk(busy == 0, "R1 busy in reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!req && !urgent && !cmd && !busy, "R1 outputs after reset",
        {req, urgent, cmd, busy}, 0);
  endtask

  task automatic t_first_expiry;
    hint = 1'b0;
    while (edges != IVL - 1) @(negedge clk);
    chk(req == 0, "R2 no request before expiry", req, 0);
    @(negedge clk);
    chk(req == 1, "R2 request after first expiry", req, 1);
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    chk(cmd == 1, "R7 command after grant", cmd, 1);
    chk(busy == 1, "R9 busy with command", busy, 1);
    @(negedge clk);
    chk(cmd == 0, "R7 single-cycle strobe", cmd, 0);
  endtask

  task automatic t_grant_without_req;
    int seen;
    seen = 0;
    while (busy) @(negedge clk);
    grant = 1'b1;
    repeat (6) begin
      @(negedge clk);
      if (cmd) seen++;
    end
    grant = 1'b0;
    chk(seen == 0, "R8 grant without request ignored", seen, 0);
  endtask

  task automatic t_postpone;
    hint = 1'b1;
    while (model != MAXD - 1) @(negedge clk);
    chk(req == 0, "R4 deferred at debt 7", req, 0);
    chk(urgent == 0, "R5 not urgent at debt 7", urgent, 0);
    while (model != MAXD) @(negedge clk);
    chk(urgent == 1, "R5 urgent at limit", urgent, 1);
    chk(req == 1, "R5 request with urgent", req, 1);
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    chk(cmd == 1, "R7 urgent refresh issued", cmd, 1);
    chk(urgent == 0, "R5 urgent drops after pay", urgent, 0);
    while (busy) @(negedge clk);
    chk(req == 0, "R4 deferred again after busy", req, 0);
  endtask

  task automatic t_catch_up;
    int last, gaps, guard;
    last = -1; gaps = 0; guard = 0;
    hint = 1'b0;
    grant = 1'b1;
    while (!(model == 0 && !busy) && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (cmd) begin
        if (last >= 0) begin
          chk(guard - last == TRFC + 1, "R9 catch-up spacing", guard - last, TRFC + 1);
          gaps++;
        end
        last = guard;
      end
    end
    grant = 1'b0;
    chk(gaps >= MAXD - 2, "R3 debt drained by quiet traffic", gaps, MAXD - 2);
    @(negedge clk);
    chk(req == 0, "R3 no request with zero debt", req, 0);
  endtask

  task automatic t_max_gap;
    hint = 1'b1;
    max_gap = 0;
    repeat (3 * (MAXD + 1) * IVL) begin
      @(negedge clk);
      grant = urgent;
    end
    grant = 1'b0;
    chk(max_gap > 0 && max_gap <= (MAXD + 1) * IVL, "R10 worst gap between refreshes",
        max_gap, (MAXD + 1) * IVL);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_first_expiry();
    t_grant_without_req();
    t_postpone();
    t_catch_up();
    t_max_gap();
    chk(mis_r3 == 0, "R3 request only with debt", mis_r3, 0);
    chk(mis_r5 == 0, "R5 urgent tracks limit", mis_r5, 0);
    chk(mis_r6 == 0, "R6 debt stays within 0..8", mis_r6, 0);
    chk(mis_r9 == 0, "R9 busy window length", mis_r9, 0);
    done = 1'b1;
    summary();
  end

endmodule